// File: doc/BRIEF.md
# SIMD Pairwise Add Unit

This unit folds neighbouring lanes of SIMD operands into sums. It has two forms. In the vector form it takes two source operands, N and M, and treats them as one double-width value with M in the upper part. It adds every even lane of that value to the odd lane just above it. The result therefore carries the pair sums from N in its lower half and the pair sums from M in its upper half. In the scalar form it adds the two 64-bit lanes of N and returns that sum in the low 64 bits.

The unit decodes a 32-bit instruction word to pick the form, the lane width (8, 16, 32 or 64 bits) and, in the vector form, full or half width. Register-number fields are carried in the word but are not used here, because the caller reads the operands. Every accepted word produces one registered result one cycle later, together with a valid strobe and a flag that marks encodings the unit rejects.

Top module: `simd_pairsum_unit`

## Requirements
- R1: Vector form is recognised when bit31=0, bit29=0, bits[28:24]=01110, bit21=1, bits[15:11]=10111 and bit10=1. Bit30 is the width bit Q, and bits[23:22] select the lane width: 00=8, 01=16, 10=32, 11=64. With Q=1 and lane width W, result lane i for i below 64/W holds N lane 2i plus N lane 2i+1. Result lane 64/W+i holds M lane 2i plus M lane 2i+1.
- R2: Every sum wraps modulo 2 to the power of its lane width. No carry crosses into a neighbouring lane.
- R3: With Q=0, only the low 64 bits of N and of M are used. The result's low 64 bits hold the pair sums of N's low half, followed above them by the pair sums of M's low half. The upper 64 result bits are zero.
- R4: A vector-form word with Q=0 and size 11 is rejected as illegal.
- R5: Scalar form is recognised when bits[31:30]=01, bits[28:24]=11110, bits[21:17]=11000 and bits[11:10]=10. Bit29 is U, bits[23:22] are the size and bits[16:12] are the opcode. With U=0, size=11 and opcode=11011, the low 64 result bits are N[63:0]+N[127:64] (wrapping) and the upper 64 bits are zero.
- R6: A scalar-form word whose fixed fields match but whose U, size or opcode differ from R5 is rejected as illegal.
- R7: A word that matches neither layout is rejected as illegal. This includes a vector layout with U=1 or with any other opcode.
- R8: For a rejected word, out_illegal is 1 and out_result is zero in the output cycle.
- R9: out_valid is 1 exactly in the cycle after in_valid is 1. out_result and out_illegal change only in those cycles and otherwise hold their values.
- R10: While rst_n is low, out_valid, out_illegal and out_result are all zero.
- R11: Register-number fields (bits[20:16], [9:5] and [4:0]) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are present |
| in_insn | input | 32 | Instruction word |
| in_src_n | input | VEC_W | Operand N |
| in_src_m | input | VEC_W | Operand M |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | VEC_W | Pairwise sum result |
| out_illegal | output | 1 | The word was rejected |

## Verification
The bench builds the unit with its default 128-bit operand width. At that width both vector widths and all four lane sizes are reachable, as are the scalar fold and the half-width case where the upper half is cleared. A lane-looping reference model in the bench is compared with every result. All-ones operands make every lane carry out, which exposes any carry that leaks between lanes. Rejected words cover each scalar field that can differ and the reserved half-width 64-bit case.

// File: rtl/pairsum_pkg.sv
package pairsum_pkg;

   localparam int INSN_W = 32;
   localparam int NUM_SIZES = 4;
   localparam int SCALAR_LANE_W = 64;

   typedef enum logic [1:0] {
      PS_REJECT   = 2'd0,
      PS_VEC_FULL = 2'd1,
      PS_VEC_HALF = 2'd2,
      PS_SCALAR   = 2'd3
   } ps_form_e;

   function automatic int lane_width(input int size_code);
      return 8 << size_code;
   endfunction

endpackage

// File: rtl/pairsum_fold.sv
module pairsum_fold #(
   parameter int IN_W   = 256,
   parameter int LANE_W = 8,
   localparam int OUT_W  = IN_W / 2,
   localparam int NPAIRS = IN_W / (2 * LANE_W)
) (
   input  logic [IN_W-1:0]  src,
   output logic [OUT_W-1:0] sums
);

   if (LANE_W < 1 || (IN_W % (2 * LANE_W)) != 0) begin : g_bad_geometry
      $error("pairsum_fold: IN_W must be a multiple of twice LANE_W");
   end

   for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
      assign sums[p*LANE_W +: LANE_W] =
         src[(2*p)*LANE_W +: LANE_W] + src[(2*p+1)*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/pairsum_decode.sv
module pairsum_decode
   import pairsum_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output ps_form_e          form,
   output logic [1:0]        size_code
);

   logic vec_layout;
   logic vec_q;
   logic scl_layout;
   logic scl_op_ok;

   always_comb begin
      vec_layout = (insn[31] == 1'b0) && (insn[29] == 1'b0) &&
                   (insn[28:24] == 5'b01110) && insn[21] &&
                   (insn[15:11] == 5'b10111) && insn[10];
      vec_q      = insn[30];
      scl_layout = (insn[31:30] == 2'b01) && (insn[28:24] == 5'b11110) &&
                   (insn[21:17] == 5'b11000) && (insn[11:10] == 2'b10);
      scl_op_ok  = (insn[29] == 1'b0) && (insn[23:22] == 2'b11) &&
                   (insn[16:12] == 5'b11011);
      size_code  = insn[23:22];

      form = PS_REJECT;
      if (vec_layout) begin
         if (vec_q) form = PS_VEC_FULL;
         else if (insn[23:22] != 2'b11) form = PS_VEC_HALF;
      end else if (scl_layout && scl_op_ok) begin
         form = PS_SCALAR;
      end
   end

endmodule

// File: rtl/pairsum_datapath.sv
module pairsum_datapath
   import pairsum_pkg::*;
#(
   parameter int VEC_W = 128,
   localparam int HALF_W = VEC_W / 2
) (
   input  logic [VEC_W-1:0] src_n,
   input  logic [VEC_W-1:0] src_m,
   input  ps_form_e         form,
   input  logic [1:0]       size_code,
   output logic [VEC_W-1:0] result
);

   if (VEC_W < 128 || (VEC_W % 128) != 0) begin : g_bad_width
      $error("pairsum_datapath: VEC_W must be a multiple of 128");
   end

   logic [VEC_W-1:0]  full_sum [NUM_SIZES];
   logic [HALF_W-1:0] half_sum [NUM_SIZES];
   logic [HALF_W-1:0] half_n;
   logic [HALF_W-1:0] half_m;

   assign half_n = src_n[HALF_W-1:0];
   assign half_m = src_m[HALF_W-1:0];

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      pairsum_fold #(
         .IN_W   (2 * VEC_W),
         .LANE_W (lane_width(s))
      ) i_full (
         .src  ({src_m, src_n}),
         .sums (full_sum[s])
      );

      pairsum_fold #(
         .IN_W   (VEC_W),
         .LANE_W (lane_width(s))
      ) i_half (
         .src  ({half_m, half_n}),
         .sums (half_sum[s])
      );
   end

   // Scalar fold reuses the 64-bit full-width adder on N's two low lanes.
   always_comb begin
      result = '0;
      case (form)
         PS_VEC_FULL: result = full_sum[size_code];
         PS_VEC_HALF: result[HALF_W-1:0] = half_sum[size_code];
         PS_SCALAR:   result[SCALAR_LANE_W-1:0] = full_sum[3][SCALAR_LANE_W-1:0];
         default:     result = '0;
      endcase
   end

endmodule

// File: rtl/simd_pairsum_unit.sv
module simd_pairsum_unit
   import pairsum_pkg::*;
#(
   parameter int VEC_W = 128,
   localparam int HALF_W = VEC_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [INSN_W-1:0]  in_insn,
   input  logic [VEC_W-1:0]   in_src_n,
   input  logic [VEC_W-1:0]   in_src_m,
   output logic               out_valid,
   output logic [VEC_W-1:0]   out_result,
   output logic               out_illegal
);

   ps_form_e         dec_form;
   logic [1:0]       dec_size;
   logic [VEC_W-1:0] dp_result;

   pairsum_decode i_decode (
      .insn      (in_insn),
      .form      (dec_form),
      .size_code (dec_size)
   );

   pairsum_datapath #(
      .VEC_W (VEC_W)
   ) i_datapath (
      .src_n     (in_src_n),
      .src_m     (in_src_m),
      .form      (dec_form),
      .size_code (dec_size),
      .result    (dp_result)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_illegal <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= dp_result;
            out_illegal <= (dec_form == PS_REJECT);
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                       // R9
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                     // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_illegal)));  // R9
   AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> (out_result == '0));                           // R8
   AST_REJECT_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !out_valid) |=> (out_valid && !$stable(out_valid))); // R9
   AST_HALF_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec_form == PS_VEC_HALF) |=> (out_result[VEC_W-1:HALF_W] == '0)); // R3
   AST_SCALAR_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dec_form == PS_SCALAR) |=> (out_result[VEC_W-1:SCALAR_LANE_W] == '0)); // R5

endmodule

// File: tb/test_simd_pairsum_unit.sv
module test_simd_pairsum_unit;

   localparam int CLK_PERIOD = 10;
   localparam int VW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   in_insn = '0;
   logic [VW-1:0] in_src_n = '0;
   logic [VW-1:0] in_src_m = '0;
   logic          out_valid;
   logic [VW-1:0] out_result;
   logic          out_illegal;

   int n_checks = 0;
   int n_fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_pairsum_unit #(.VEC_W(VW)) i_simd_pairsum_unit (
      .clk, .rst_n, .in_valid, .in_insn, .in_src_n, .in_src_m,
      .out_valid, .out_result, .out_illegal
   );

   function automatic logic [31:0] vec_word(input bit q, input bit u,
         input logic [1:0] sz, input logic [4:0] opc, input logic [14:0] regs);
      return {1'b0, q, u, 5'b01110, sz, 1'b1, regs[14:10], opc, 1'b1, regs[9:0]};
   endfunction

   function automatic logic [31:0] scl_word(input bit u, input logic [1:0] sz,
         input logic [4:0] opc, input logic [9:0] regs);
      return {2'b01, u, 5'b11110, sz, 5'b11000, opc, 2'b10, regs};
   endfunction

   function automatic void ref_model(input logic [31:0] w, input logic [127:0] n,
         input logic [127:0] m, output logic [127:0] r, output bit ill);
      logic [255:0] cat, a, b, mask;
      int lw, nres;
      r = '0; ill = 1'b1;
      if (w[31] == 0 && w[29] == 0 && w[28:24] == 5'b01110 && w[21] &&
          w[15:11] == 5'b10111 && w[10]) begin
         if (!(w[30] == 0 && w[23:22] == 2'b11)) begin
            ill = 1'b0;
            lw = 8 << w[23:22];
            cat = w[30] ? {m, n} : {128'b0, m[63:0], n[63:0]};
            nres = (w[30] ? 128 : 64) / lw;
            mask = (256'b1 << lw) - 256'b1;
            for (int i = 0; i < nres; i++) begin
               a = (cat >> (2*i*lw)) & mask;
               b = (cat >> ((2*i+1)*lw)) & mask;
               r = r | 128'(((a + b) & mask) << (i*lw));
            end
         end
      end else if (w[31:30] == 2'b01 && w[28:24] == 5'b11110 &&
                   w[21:17] == 5'b11000 && w[11:10] == 2'b10 &&
                   w[29] == 0 && w[23:22] == 2'b11 && w[16:12] == 5'b11011) begin
         ill = 1'b0;
         r = {64'b0, n[63:0] + n[127:64]};
      end
   endfunction

   task automatic check(input string tag, input logic [127:0] act,
                        input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Issue one word; outputs are sampled at the falling edge after the capture edge.
   task automatic issue(input string tag, input logic [31:0] w,
                        input logic [127:0] n, input logic [127:0] m,
                        output logic [127:0] res);
      logic [127:0] er; bit ei;
      ref_model(w, n, m, er, ei);
      @(negedge clk);
      in_valid = 1'b1; in_insn = w; in_src_n = n; in_src_m = m;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " valid"}, 128'(out_valid), 128'(1));
      check({tag, " illegal"}, 128'(out_illegal), 128'(ei));
      check({tag, " result"}, out_result, er);
      res = out_result;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic t_reset();
      check("R10 valid in reset", 128'(out_valid), 128'(0));
      check("R10 illegal in reset", 128'(out_illegal), 128'(0));
      check("R10 result in reset", out_result, 128'(0));
   endtask

   task automatic t_vector_full();
      logic [127:0] r;
      for (int s = 0; s < 4; s++)
         for (int k = 0; k < 3; k++)
            issue("R1 full", vec_word(1, 0, 2'(s), 5'b10111, 15'(k*77)),
                  rnd128(), rnd128(), r);
      issue("R1 full ramp", vec_word(1, 0, 2'b00, 5'b10111, '0),
            128'h0f0e0d0c0b0a09080706050403020100,
            128'h1f1e1d1c1b1a19181716151413121110, r);
   endtask

   task automatic t_wrap();
      logic [127:0] r;
      for (int s = 0; s < 4; s++) begin
         issue("R2 wrap", vec_word(1, 0, 2'(s), 5'b10111, '0), '1, '1, r);
         // every lane is all ones, so each sum is all ones minus one in its lane
      end
      issue("R2 wrap exact b", vec_word(1, 0, 2'b00, 5'b10111, '0), '1, '1, r);
      check("R2 byte lanes fe", r, {16{8'hfe}});
   endtask

   task automatic t_vector_half();
      logic [127:0] r;
      for (int s = 0; s < 3; s++)
         for (int k = 0; k < 3; k++)
            issue("R3 half", vec_word(0, 0, 2'(s), 5'b10111, '0),
                  rnd128(), rnd128(), r);
      issue("R3 half 32", vec_word(0, 0, 2'b10, 5'b10111, '0),
            {64'hdead, 32'd5, 32'd7}, {64'hbeef, 32'd1, 32'd2}, r);
      check("R3 half 32 exact", r, {64'b0, 32'd3, 32'd12});
      issue("R4 half 64 rejected", vec_word(0, 0, 2'b11, 5'b10111, '0),
            rnd128(), rnd128(), r);
   endtask

   task automatic t_scalar();
      logic [127:0] r;
      for (int k = 0; k < 3; k++)
         issue("R5 scalar", scl_word(0, 2'b11, 5'b11011, 10'(k*33)),
               rnd128(), rnd128(), r);
      issue("R5 scalar wrap", scl_word(0, 2'b11, 5'b11011, '0),
            {64'hffffffffffffffff, 64'h2}, '1, r);
      check("R5 scalar exact", r, 128'h1);
   endtask

   task automatic t_scalar_reject();
      logic [127:0] r;
      issue("R6 scalar U=1", scl_word(1, 2'b11, 5'b11011, '0), '1, '1, r);
      issue("R6 scalar size 10", scl_word(0, 2'b10, 5'b11011, '0), '1, '1, r);
      issue("R6 scalar opcode", scl_word(0, 2'b11, 5'b11010, '0), '1, '1, r);
      check("R8 rejected zero", r, 128'h0);
   endtask

   task automatic t_foreign();
      logic [127:0] r;
      issue("R7 vector U=1", vec_word(1, 1, 2'b00, 5'b10111, '0), '1, '1, r);
      issue("R7 vector opcode", vec_word(1, 0, 2'b01, 5'b10110, '0), '1, '1, r);
      issue("R7 scalar bad fixed", scl_word(0, 2'b11, 5'b11011, '0) ^ 32'h0000_0400,
            '1, '1, r);
      issue("R7 zero word", 32'h0, '1, '1, r);
      check("R8 foreign zero", r, 128'h0);
   endtask

   task automatic t_hold();
      logic [127:0] r;
      issue("R9 prime", vec_word(1, 0, 2'b01, 5'b10111, '0), rnd128(), rnd128(), r);
      @(negedge clk);
      in_insn = 32'h0; in_src_n = rnd128(); in_src_m = rnd128();
      repeat (3) @(negedge clk);
      check("R9 idle no strobe", 128'(out_valid), 128'(0));
      check("R9 idle holds result", out_result, r);
      check("R9 idle holds flag", 128'(out_illegal), 128'(0));
   endtask

   task automatic t_regfields();
      logic [127:0] n, m, r0, r1;
      n = rnd128(); m = rnd128();
      issue("R11 regs a", vec_word(1, 0, 2'b10, 5'b10111, 15'h0000), n, m, r0);
      issue("R11 regs b", vec_word(1, 0, 2'b10, 5'b10111, 15'h7fff), n, m, r1);
      check("R11 same result", r1, r0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_vector_full();
      t_wrap();
      t_vector_half();
      t_scalar();
      t_scalar_reject();
      t_foreign();
      t_hold();
      t_regfields();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule